// File: doc/BRIEF.md
# Cascaded Fall-Through FIFO Chain

This block builds one deep first-in first-out buffer out of a row of identical fall-through stages. Each stage holds a small memory plus an output register that presents the oldest word without waiting for a read. The stages sit in series. A stage's data output wires straight to the next stage's data input. Its active-low "output ready" line acts as the next stage's active-low write enable. The next stage's active-low "input ready" line acts as its own active-low read enable. No logic sits between two stages.

A word written into an empty chain moves forward one stage at a time, with no read, until it sits on the last stage's output. A word read from a full chain opens a free slot that moves backward one stage at a time until the first stage can accept again. Write, transfer and read all run on one clock. A synchronous active-high reset empties every stage.

Users drive `wr_en_n` low to push `wr_data` while `in_ready_n` is low. They drive `rd_en_n` low to take `rd_data` while `out_ready_n` is low.

Top module: `fwft_chain`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_ready_n` is 1 (no data) and `in_ready_n` is 0 (room available).
- R2: Words leave in exactly the order they were accepted and with unchanged values. While `out_ready_n` is 0 and `rd_en_n` is 1, the next cycle still shows `out_ready_n` 0 and the same `rd_data`.
- R3: With no reads, the chain accepts exactly STAGES*STAGE_DEPTH words. After that, `in_ready_n` is 1.
- R4: A write is accepted only on a rising edge where `wr_en_n` and `in_ready_n` are both 0. A write attempted while `in_ready_n` is 1 adds no word to the output stream.
- R5: A read is taken only on a rising edge where `rd_en_n` and `out_ready_n` are both 0. Reads attempted on an empty chain change nothing, so the next word written is the next word delivered.
- R6: When a word is written into an empty chain, `out_ready_n` first goes to 0 right after the (2*STAGES-1)-th rising edge that follows the write edge.
- R7: Once the chain is full and settled, holding `rd_en_n` at 0 delivers one word on every clock, with `out_ready_n` staying 0, until the chain is empty.
- R8: When one word is read from a full, settled chain, `in_ready_n` first goes to 0 right after the (STAGES-1)-th rising edge that follows the read edge. With a single stage, this happens at the read edge itself.
- R9: Under arbitrary mixes of concurrent write and read enables, no word is lost, duplicated or reordered, and a final drain leaves the chain empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for write, inter-stage transfer and read |
| rst | input | 1 | Synchronous active-high reset, empties all stages |
| wr_en_n | input | 1 | Active-low write enable into the first stage |
| wr_data | input | WIDTH | Word to write |
| in_ready_n | output | 1 | Active-low: first stage has room |
| rd_en_n | input | 1 | Active-low read enable on the last stage |
| rd_data | output | WIDTH | Oldest word in the chain, valid when out_ready_n is 0 |
| out_ready_n | output | 1 | Active-low: last stage holds a valid word |

## Verification
The bench counts the cycles from a write into an empty chain until data shows at the far end. It also counts the cycles from a read of a full chain until the first stage reopens, for one to four stages. A stage that added or skipped a register in its ripple or bubble path would miss those counts. The bench fills the chain while it keeps trying to write, then drains it with back-to-back reads. A wrong full test would accept one word too many or too few. A refill path that leaves gaps would drop `out_ready_n` in the middle of the drain. Reads on an empty chain and long random mixed traffic are checked against a queue, which catches a popped phantom word or a duplicated word at a stage boundary.

// File: rtl/fwft_chain_pkg.sv
package fwft_chain_pkg;

  // Address width for a memory of d entries (at least one bit).
  function automatic int unsigned addr_w(input int unsigned d);
    return (d <= 1) ? 1 : $clog2(d);
  endfunction

  // Width needed to count from 0 up to d inclusive.
  function automatic int unsigned cnt_w(input int unsigned d);
    return $clog2(d + 1);
  endfunction

endpackage

// File: rtl/fwft_sdp_ram.sv
module fwft_sdp_ram #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 3,
  parameter int unsigned AW    = 2
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Simple dual-port array with registered read: block RAM friendly.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/fwft_stage.sv
module fwft_stage
  import fwft_chain_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wen_n,
  input  logic [WIDTH-1:0] din,
  output logic             ir_n,
  input  logic             ren_n,
  output logic [WIDTH-1:0] dout,
  output logic             or_n
);

  // One word lives in the output register, the rest in the array.
  localparam int unsigned MEM = DEPTH - 1;
  localparam int unsigned AW  = addr_w(MEM);
  localparam int unsigned CW  = cnt_w(MEM);

  logic [CW-1:0] count;
  logic [AW-1:0] wptr, rptr;
  logic          valid;
  logic          full, do_wr, do_rd, load;

  assign full  = (count == CW'(MEM));
  assign do_wr = !wen_n && !full;
  assign do_rd = !ren_n && valid;
  assign load  = (!valid || do_rd) && (count != '0);

  fwft_sdp_ram #(.WIDTH(WIDTH), .DEPTH(MEM), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (do_wr),
    .waddr (wptr),
    .wdata (din),
    .re    (load),
    .raddr (rptr),
    .rdata (dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      wptr  <= '0;
      rptr  <= '0;
      valid <= 1'b0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(MEM - 1)) ? '0 : wptr + AW'(1);
      if (load)  rptr <= (rptr == AW'(MEM - 1)) ? '0 : rptr + AW'(1);
      if (do_wr && !load)      count <= count + CW'(1);
      else if (!do_wr && load) count <= count - CW'(1);
      if (load)       valid <= 1'b1;
      else if (do_rd) valid <= 1'b0;
    end
  end

  assign ir_n = full;
  assign or_n = !valid;

endmodule

// File: rtl/fwft_chain.sv
module fwft_chain #(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned STAGES      = 3,
  parameter int unsigned STAGE_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             in_ready_n,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             out_ready_n
);

  logic [WIDTH-1:0] dat [STAGES+1];
  logic             orn [STAGES];
  logic             irn [STAGES];

  assign dat[0] = wr_data;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic wen_k, ren_k;
    if (k == 0) begin : g_head
      assign wen_k = wr_en_n;
    end else begin : g_link_in
      assign wen_k = orn[k-1];
    end
    if (k == STAGES - 1) begin : g_tail
      assign ren_k = rd_en_n;
    end else begin : g_link_out
      assign ren_k = irn[k+1];
    end

    fwft_stage #(.WIDTH(WIDTH), .DEPTH(STAGE_DEPTH)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .wen_n (wen_k),
      .din   (dat[k]),
      .ir_n  (irn[k]),
      .ren_n (ren_k),
      .dout  (dat[k+1]),
      .or_n  (orn[k])
    );
  end

  assign in_ready_n  = irn[0];
  assign out_ready_n = orn[STAGES-1];
  assign rd_data     = dat[STAGES];

endmodule

// File: rtl/fwft_chain_chk.sv
module fwft_chain_chk #(
  parameter int unsigned WIDTH = 16,
  parameter int          CAP   = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en_n,
  input logic             in_ready_n,
  input logic             rd_en_n,
  input logic             out_ready_n,
  input logic [WIDTH-1:0] rd_data
);

  int occ;
  logic wr_acc, rd_acc;

  assign wr_acc = !wr_en_n && !in_ready_n;
  assign rd_acc = !rd_en_n && !out_ready_n;

  always_ff @(posedge clk) begin
    if (rst) occ <= 0;
    else     occ <= occ + (wr_acc ? 1 : 0) - (rd_acc ? 1 : 0);
  end

  // R1
  reset_flags_chk: assert property (@(posedge clk)
    rst |=> (out_ready_n && !in_ready_n));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CAP);

  // R3
  full_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == CAP) |-> in_ready_n);

  // R5
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == 0) |-> out_ready_n);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_ready_n && rd_en_n) |=> (!out_ready_n && $stable(rd_data)));

endmodule

bind fwft_chain fwft_chain_chk #(
  .WIDTH (WIDTH),
  .CAP   (STAGES * STAGE_DEPTH)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en_n     (wr_en_n),
  .in_ready_n  (in_ready_n),
  .rd_en_n     (rd_en_n),
  .out_ready_n (out_ready_n),
  .rd_data     (rd_data)
);

// File: tb/fwft_chain_tb.sv
`timescale 1ns/1ps

module fwft_chain_tb_core #(
  parameter int N = 1,
  parameter int D = 4,
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   checks,
  output int   fails
);

  localparam int CAP = N * D;

  logic         wen_n, ren_n;
  logic [W-1:0] wd;
  logic [W-1:0] rd;
  logic         irn, orn;

  fwft_chain #(.WIDTH(W), .STAGES(N), .STAGE_DEPTH(D)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .wr_en_n     (wen_n),
    .wr_data     (wd),
    .in_ready_n  (irn),
    .rd_en_n     (ren_n),
    .rd_data     (rd),
    .out_ready_n (orn)
  );

  logic [W-1:0] q[$];
  logic [W-1:0] seq;
  int accepted, popped;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL stages=%0d %s actual=%0d expected=%0d", N, req, act, exp);
    end
  endtask

  // Drive at the falling edge, then model the rising edge that follows.
  task automatic cyc(input bit wn, input bit rn);
    @(negedge clk);
    wen_n = wn;
    ren_n = rn;
    wd    = seq;
    #1;
    if (!orn) chk(q.size() > 0, "R2 data shown on empty model", 1, 0);
    if (!ren_n && !orn) begin
      if (q.size() == 0) chk(1'b0, "R2 read with empty model", int'(rd), -1);
      else begin
        chk(rd == q[0], "R2 order/value", int'(rd), int'(q[0]));
        void'(q.pop_front());
        popped++;
      end
    end
    if (!wen_n && !irn) begin
      q.push_back(wd);
      seq = seq + W'(1);
      accepted++;
    end
  endtask

  initial begin
    int lat, acc0;
    done = 0; checks = 0; fails = 0;
    wen_n = 1; ren_n = 1; wd = '0; seq = W'(16'h100 * N);
    accepted = 0; popped = 0;
    @(negedge clk);
    while (rst) @(negedge clk);

    // R1 flags right after reset
    cyc(1, 1);
    chk(orn == 1'b1, "R1 out_ready_n", int'(orn), 1);
    chk(irn == 1'b0, "R1 in_ready_n", int'(irn), 0);

    // R5 reads on an empty chain do nothing
    for (int i = 0; i < 8; i++) begin
      cyc(1, 0);
      chk(orn == 1'b1, "R5 empty read", int'(orn), 1);
    end

    // R6 first-word ripple latency
    cyc(0, 1);
    lat = 0;
    do begin cyc(1, 1); lat++; end while (orn && lat < 100);
    chk(lat == 2 * N, "R6 first word latency", lat, 2 * N);
    cyc(1, 0);
    cyc(1, 1);
    chk(orn == 1'b1, "R5 empty after single word", int'(orn), 1);

    // R3 and R4: keep writing well past capacity
    acc0 = accepted;
    for (int i = 0; i < 2 * CAP + 4 * N + 8; i++) cyc(0, 1);
    chk(accepted - acc0 == CAP, "R3 words accepted", accepted - acc0, CAP);
    chk(irn == 1'b1, "R3 in_ready_n when full", int'(irn), 1);
    for (int i = 0; i < 4 * N + 8; i++) cyc(1, 1);

    // R8 first free slot latency
    chk(irn == 1'b1, "R8 full before read", int'(irn), 1);
    cyc(1, 0);
    lat = 0;
    do begin cyc(1, 1); lat++; end while (irn && lat < 100);
    chk(lat == N, "R8 free slot latency", lat, N);

    // R7 back-to-back drain without gaps
    for (int i = 0; i < 4 * N + 8; i++) cyc(1, 1);
    for (int i = 0; i < CAP - 1; i++) begin
      cyc(1, 0);
      chk(orn == 1'b0, "R7 gapless drain", int'(orn), 0);
    end
    cyc(1, 1);
    chk(orn == 1'b1, "R7 empty after drain", int'(orn), 1);
    chk(q.size() == 0, "R4 no extra words", q.size(), 0);
    chk(popped == accepted, "R4 delivered equals accepted", popped, accepted);

    // R9 random concurrent traffic in three phases
    void'($urandom(N * 7 + 3));
    for (int i = 0; i < 3000; i++) begin
      int rw, rr;
      rw = $urandom_range(0, 3);
      rr = $urandom_range(0, 3);
      if (i < 1000)      cyc(rw == 0, rr != 0);
      else if (i < 2000) cyc(rw != 0, rr == 0);
      else               cyc(rw[0], rr[0]);
    end
    for (int i = 0; i < 2 * CAP + 4 * N + 20; i++) cyc(1, 0);
    chk(q.size() == 0, "R9 drained model empty", q.size(), 0);
    chk(orn == 1'b1, "R9 chain empty", int'(orn), 1);
    chk(popped == accepted, "R9 no loss or duplication", popped, accepted);

    done = 1;
  end

endmodule

module fwft_chain_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic timeout = 1'b0;
  logic done_a [4];
  int   chk_a  [4];
  int   fail_a [4];

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_n
    fwft_chain_tb_core #(.N(g + 1)) u_core (
      .clk    (clk),
      .rst    (rst),
      .done   (done_a[g]),
      .checks (chk_a[g]),
      .fails  (fail_a[g])
    );
  end

  initial begin
    repeat (150000) @(posedge clk);
    timeout = 1'b1;
  end

  initial begin
    int tc, tf;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    wait ((done_a[0] && done_a[1] && done_a[2] && done_a[3]) || timeout);
    tc = 0; tf = 0;
    for (int i = 0; i < 4; i++) begin
      tc += chk_a[i];
      tf += fail_a[i];
    end
    if (timeout) begin
      tc++; tf++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", tc, tf);
    $finish;
  end

endmodule